// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between a processor-side 32-bit request port and a word-addressed memory port. A fixed 32 MB alias window stands for a smaller bit-band region. Each word in that window stands for one bit of one byte in the region. Software can therefore set, clear or test a single bit with an ordinary word access.

A read of an alias word returns the addressed bit, zero-extended to a full word. A write to an alias word is turned into a locked pair of memory cycles. The first cycle reads the word that holds the target byte. The second writes back the same word with only the addressed bit changed. Only requests whose master ID marks them as coming from the processor are translated. Requests from other masters, and every address outside the window, go through to memory untouched.

The memory port completes a cycle when `mem_valid` and `mem_ready` are both high, and read data is valid in that same cycle. The request port follows the same rule with `req_valid` and `req_ready`. The requester must hold its request steady until `req_ready` is high.

Top module: `bitband_xlate`

## Requirements
- R1: An alias address A maps to byte B = REGION_BASE + (A - ALIAS_BASE)[24:5] and bit (A - ALIAS_BASE)[4:2] of that byte, where (A - ALIAS_BASE)[24:5] is the byte offset. The memory word address driven is B[31:2], and the byte lane is B[1:0]. Example: alias 0x22006008 maps to byte 0x20000300, bit 2, memory word 0x080000C0.
- R2: An in-span alias read from the processor makes one memory read. It returns 0x00000001 when the target bit is set and 0x00000000 when it is clear. It completes in the same cycle as that memory read.
- R3: An in-span alias write from the processor changes only the addressed bit of the memory word. The new bit value is taken from bit 0 of the write data, and all other write-data bits are ignored.
- R4: The write-back cycle of an alias write is a memory write whose byte enable has exactly one bit set, the bit for the target byte lane.
- R5: An alias write uses exactly two memory handshakes, a read followed by a write. `req_ready` stays low until the write handshake and is high in that cycle, so with a memory that is always ready the request completes one cycle after it is presented.
- R6: A processor alias address whose byte offset is REGION_BYTES or more gets `rsp_err` high. `req_ready` is high in the same cycle, and no memory cycle is made.
- R7: An address outside the alias window is forwarded unchanged: word address `req_addr[31:2]`, byte enables, write data and direction. Memory read data is returned as is, with `rsp_err` low.
- R8: An alias-window address from a master whose ID is not CPU_ID is forwarded untranslated, in the same way as R7.
- R9: After reset, and whenever `req_valid` is low, `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completes this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_mid | input | MID_W | Master ID |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_err | output | 1 | Error response, valid with req_ready |
| mem_valid | output | 1 | Memory cycle request |
| mem_ready | input | 1 | Memory cycle completes |
| mem_write | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
Pass-through accesses, alias reads and error responses complete in the cycle they are presented. So the bench looks at `req_ready`, `rsp_rdata` and `rsp_err` a few time units after it drives inputs on the falling edge, and expects no wait cycles. An alias write must wait exactly one cycle with a memory that is always ready. The bench counts the falling edges until `req_ready` rises and checks that this count is one. With a memory that stalls every other cycle, the bench checks instead that exactly two memory handshakes occur. The bench checks the memory contents and the logged memory cycle after the clock edge on which the request completes.

// File: rtl/bb_pkg.sv
package bb_pkg;
   localparam int WORD_W  = 32;
   localparam int LANES   = WORD_W / 8;
   localparam int LANE_W  = $clog2(LANES);
   localparam int WIN_LOG2 = 25;
   typedef enum logic {ST_IDLE, ST_WB} rmw_st_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h2200_0000,
   parameter int                REGION_BYTES = 1024
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_win,
   output logic              in_span,
   output logic [ADDR_W-3:0] word_addr,
   output logic [1:0]        lane,
   output logic [2:0]        bitn
);
   import bb_pkg::*;
   localparam int OFF_W = WIN_LOG2 - 5;

   if (REGION_BYTES > (1 << OFF_W) || REGION_BYTES < 1) begin : g_bad_span
      $error("REGION_BYTES must be 1..2^20");
   end
   if (ADDR_W <= WIN_LOG2) begin : g_bad_aw
      $error("ADDR_W too small for the alias window");
   end

   logic [ADDR_W-1:0] offs;
   logic [OFF_W-1:0]  byte_off;
   logic [ADDR_W-1:0] tgt;

   always_comb begin
      offs      = addr - ALIAS_BASE;
      in_win    = (addr[ADDR_W-1:WIN_LOG2] == ALIAS_BASE[ADDR_W-1:WIN_LOG2]);
      byte_off  = offs[WIN_LOG2-1:5];
      in_span   = ({{(32-OFF_W){1'b0}}, byte_off} < 32'(REGION_BYTES));
      tgt       = REGION_BASE + {{(ADDR_W-OFF_W){1'b0}}, byte_off};
      word_addr = tgt[ADDR_W-1:2];
      lane      = tgt[1:0];
      bitn      = offs[4:2];
   end
endmodule

// File: rtl/bb_lane.sv
module bb_lane
   import bb_pkg::*;
(
   input  logic [WORD_W-1:0] rd_word,
   input  logic [WORD_W-1:0] old_word,
   input  logic [1:0]        lane,
   input  logic [2:0]        bitn,
   input  logic              newbit,
   output logic              bit_out,
   output logic [WORD_W-1:0] new_word,
   output logic [LANES-1:0]  lane_be
);
   logic [LANES-1:0] hit;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] mask;
      assign mask       = 8'(1) << bitn;
      assign lane_be[i] = (lane == LANE_W'(i));
      assign hit[i]     = lane_be[i] & rd_word[i*8 + bitn];
      assign new_word[i*8 +: 8] = lane_be[i]
         ? ((old_word[i*8 +: 8] & ~mask) | (newbit ? mask : 8'h00))
         : old_word[i*8 +: 8];
   end

   assign bit_out = |hit;
endmodule

// File: rtl/bb_rmw.sv
module bb_rmw
   import bb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mem_ready,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              in_wb,
   output logic [WORD_W-1:0] hold_q
);
   rmw_st_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start && mem_ready) begin
               st_q   <= ST_WB;
               hold_q <= mem_rdata;
            end
            ST_WB: if (mem_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign in_wb = (st_q == ST_WB);

   // R5: the write-back phase lasts until its handshake, then ends
   a_r5_wb_exits: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wb && mem_ready) |=> !in_wb);
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] ALIAS_BASE   = 32'h2200_0000,
   parameter int                REGION_BYTES = 1024,
   parameter int                MID_W        = 2,
   parameter logic [MID_W-1:0]  CPU_ID       = '0,
   parameter bit                CPU_ONLY     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   input  logic [MID_W-1:0]  req_mid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-3:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata
);
   import bb_pkg::*;

   if (ALIAS_BASE[WIN_LOG2-1:0] != '0) begin : g_bad_align
      $error("ALIAS_BASE must be aligned to the 32 MB window");
   end

   logic              in_win, in_span, bit_out, in_wb, mid_ok;
   logic [ADDR_W-3:0] word_addr;
   logic [1:0]        lane;
   logic [2:0]        bitn;
   logic [31:0]       hold_q, new_word;
   logic [3:0]        lane_be;
   logic              xlate, err_hit, al_rd, al_wr;

   bb_decode #(.ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .ALIAS_BASE(ALIAS_BASE),
               .REGION_BYTES(REGION_BYTES)) u_dec (
      .addr(req_addr), .in_win(in_win), .in_span(in_span),
      .word_addr(word_addr), .lane(lane), .bitn(bitn));

   bb_lane u_lane (
      .rd_word(mem_rdata), .old_word(hold_q), .lane(lane), .bitn(bitn),
      .newbit(req_wdata[0]), .bit_out(bit_out), .new_word(new_word), .lane_be(lane_be));

   if (CPU_ONLY) begin : g_cpu_only
      assign mid_ok = (req_mid == CPU_ID);
   end else begin : g_all_masters
      assign mid_ok = 1'b1;
   end

   assign xlate   = req_valid && in_win && mid_ok;
   assign err_hit = xlate && !in_span;
   assign al_rd   = xlate && in_span && !req_write;
   assign al_wr   = xlate && in_span && req_write;

   bb_rmw u_rmw (
      .clk(clk), .rst_n(rst_n), .start(al_wr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .in_wb(in_wb), .hold_q(hold_q));

   always_comb begin
      mem_valid = req_valid;
      mem_write = req_write;
      mem_addr  = req_addr[ADDR_W-1:2];
      mem_be    = req_be;
      mem_wdata = req_wdata;
      req_ready = mem_ready;
      rsp_rdata = mem_rdata;
      rsp_err   = 1'b0;
      if (err_hit) begin
         mem_valid = 1'b0;
         req_ready = 1'b1;
         rsp_err   = 1'b1;
         rsp_rdata = '0;
      end else if (al_rd) begin
         mem_write = 1'b0;
         mem_addr  = word_addr;
         mem_be    = 4'hF;
         rsp_rdata = {31'b0, bit_out};
      end else if (al_wr) begin
         mem_addr  = word_addr;
         rsp_rdata = '0;
         if (!in_wb) begin
            mem_write = 1'b0;
            mem_be    = 4'hF;
            req_ready = 1'b0;
         end else begin
            mem_write = 1'b1;
            mem_be    = lane_be;
            mem_wdata = new_word;
         end
      end
   end

   // R5: no completion during the read phase of an alias write
   a_r5_ready_low_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (al_wr && !in_wb) |-> !req_ready);
   // R3: write-back is entered only after a completed memory read
   a_r3_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_wb) |-> $past(mem_valid && mem_ready && !mem_write));
   // R4: the write-back touches exactly one byte lane
   a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wb && mem_valid) |-> (mem_write && $countones(mem_be) == 1));
   // R6: an error response makes no memory cycle
   a_r6_err_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!mem_valid && req_ready));
   // R9: memory is quiet without a request
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !mem_valid);
endmodule

// File: tb/sim_bitband_xlate.sv
module sim_bitband_xlate;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0;
   logic [31:0] req_addr = 0, req_wdata = 0;
   logic [3:0]  req_be = 0;
   logic [1:0]  req_mid = 0;
   logic        req_ready, rsp_err, mem_valid, mem_write, mem_ready;
   logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
   logic [29:0] mem_addr;
   logic [3:0]  mem_be;

   int total = 0, bad = 0;
   logic [31:0] mem [256];
   int          hs_cnt = 0;
   logic [29:0] last_addr;
   logic [3:0]  last_be;
   logic [31:0] last_wdata;
   logic        last_write;
   logic        stall_mode = 0, gate = 0;

   always #2.5 clk = ~clk;

   bitband_xlate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .req_mid(req_mid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   assign mem_ready = stall_mode ? gate : 1'b1;
   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      gate <= ~gate;
      if (mem_valid && mem_ready) begin
         hs_cnt     <= hs_cnt + 1;
         last_addr  <= mem_addr;
         last_be    <= mem_be;
         last_wdata <= mem_wdata;
         last_write <= mem_write;
         if (mem_write)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[7:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic wr, input logic [31:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, input logic [1:0] mid,
                         output logic [31:0] rd, output logic err, output int waits);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = addr; req_be = be;
      req_wdata = wd; req_mid = mid;
      waits = 0;
      #1;
      while (!req_ready && waits < 20) begin
         @(negedge clk); #1; waits++;
      end
      rd = rsp_rdata; err = rsp_err;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic t_reset();
      check("R9 reset mem_valid", 32'(mem_valid), 32'd0);
   endtask

   task automatic t_alias_read();
      logic [31:0] rd; logic err; int w, h0;
      mem[8'hC0] = 32'h0000_0004;
      h0 = hs_cnt;
      do_req(0, 32'h2200_6008, 4'hF, 0, 0, rd, err, w);
      check("R2 read set bit", rd, 32'h1);
      check("R2 no wait", 32'(w), 0);
      check("R1 mapped word", 32'(last_addr), 32'h0800_00C0);
      check("R2 one mem cycle", 32'(hs_cnt - h0), 1);
      mem[8'hC0] = 32'hFFFF_FFFB;
      do_req(0, 32'h2200_6008, 4'hF, 0, 0, rd, err, w);
      check("R2 read clear bit", rd, 32'h0);
      mem[8'hC0] = 32'h8000_0000;
      do_req(0, 32'h2200_607C, 4'hF, 0, 0, rd, err, w);
      check("R1 lane3 bit7", rd, 32'h1);
   endtask

   task automatic t_alias_write();
      logic [31:0] rd; logic err; int w, h0;
      mem[8'hC0] = 32'h1234_5600;
      h0 = hs_cnt;
      do_req(1, 32'h2200_6008, 4'hF, 32'h0000_0001, 0, rd, err, w);
      check("R3 set bit2", mem[8'hC0], 32'h1234_5604);
      check("R5 one wait", 32'(w), 1);
      check("R5 two handshakes", 32'(hs_cnt - h0), 2);
      check("R4 lane0 be", 32'(last_be), 32'h1);
      do_req(1, 32'h2200_6008, 4'hF, 32'hFFFF_FFFE, 0, rd, err, w);
      check("R3 bit0 only clears", mem[8'hC0], 32'h1234_5600);
      do_req(1, 32'h2200_607C, 4'hF, 32'h0000_0001, 0, rd, err, w);
      check("R3 lane3 bit7", mem[8'hC0], 32'h9234_5600);
      check("R4 lane3 be", 32'(last_be), 32'h8);
   endtask

   task automatic t_stall_write();
      logic [31:0] rd; logic err; int w, h0;
      stall_mode = 1;
      mem[8'h05] = 32'h0;
      h0 = hs_cnt;
      do_req(1, 32'h2200_0000 + 32'h15*32 + 3*4, 4'hF, 32'h1, 0, rd, err, w);
      check("R5 stall two handshakes", 32'(hs_cnt - h0), 2);
      check("R3 stall result", mem[8'h05], 32'h0000_0800);
      stall_mode = 0;
   endtask

   task automatic t_error();
      logic [31:0] rd; logic err; int w, h0;
      h0 = hs_cnt;
      do_req(0, 32'h2200_8000, 4'hF, 0, 0, rd, err, w);
      check("R6 err flag", 32'(err), 1);
      check("R6 no wait", 32'(w), 0);
      check("R6 no mem cycle", 32'(hs_cnt - h0), 0);
   endtask

   task automatic t_pass();
      logic [31:0] rd; logic err; int w;
      mem[8'hC1] = 32'hAAAA_AAAA;
      do_req(1, 32'h2000_0304, 4'b0011, 32'h5566_7788, 0, rd, err, w);
      check("R7 addr", 32'(last_addr), 32'h0800_00C1);
      check("R7 be", 32'(last_be), 32'h3);
      check("R7 wdata", last_wdata, 32'h5566_7788);
      check("R7 mem", mem[8'hC1], 32'hAAAA_7788);
      do_req(0, 32'h2000_0304, 4'hF, 0, 0, rd, err, w);
      check("R7 read data", rd, 32'hAAAA_7788);
      check("R7 no err", 32'(err), 0);
   endtask

   task automatic t_dma();
      logic [31:0] rd; logic err; int w;
      mem[8'h02] = 32'hCAFE_0001;
      do_req(0, 32'h2200_6008, 4'hF, 0, 1, rd, err, w);
      check("R8 raw addr", 32'(last_addr), 32'h0880_1802);
      check("R8 raw data", rd, 32'hCAFE_0001);
      do_req(1, 32'h2200_6008, 4'h1, 32'h0000_00EE, 2, rd, err, w);
      check("R8 raw write", mem[8'h02], 32'hCAFE_00EE);
      check("R8 raw write flag", 32'(last_write), 1);
   endtask

   logic done = 0;
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_alias_read();
      t_alias_write();
      t_stall_write();
      t_error();
      t_pass();
      t_dma();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule